// File: doc/BRIEF.md
# Smart-Card Asynchronous Character Receiver

This block takes one serial line from a smart card and turns each asynchronous character on it into a parallel byte. The bit period is set at run time, as a number of system clocks on `cpb_i`. The line idles at 1. A character is one start bit at 0, eight data bits, one parity bit and then one or two stop bits at 1. The data bits arrive either least significant bit first or most significant bit first. Parity is odd or even, and either one or two stop bits follow.

A falling edge on the idle line opens a candidate start bit. If the line is back at 1 at the half-bit point, the event is dropped as a glitch. Otherwise the receiver runs through the character. It samples each data, parity and stop bit once, at its midpoint. At the end it reports the result through three sticky flags: byte ready, overrun and frame error. These flags stay set until `ack_i` is pulsed. Phase outputs show when a start is pending, when a character is confirmed and running, and when the stop region is reached. A one-cycle pulse marks the last clock of the character. `rx_i` must already be synchronous to `clk_i`. `cpb_i` must be at least 3 and must stay stable while a character is in progress.

Top module: `sc_char_rx`

## Requirements
- R1: After reset, `data_o`, `ready_o`, `overrun_o`, `frame_err_o`, `eoc_o`, `start_o`, `run_o` and `stop_o` are all 0.
- R2: One bit lasts `cpb_i` clocks. Each data, parity and stop bit is sampled once, at count `cpb_i>>1` inside its bit. Bytes are received correctly for odd, even and large `cpb_i` values (for example 7, 16 and 372).
- R3: With `msb_first_i`=1, the first data bit after the start bit is `data_o[7]`. With `msb_first_i`=0, the first data bit is `data_o[0]`.
- R4: With `odd_par_i`=1, the eight data bits plus the parity bit must hold an odd number of ones. With `odd_par_i`=0, they must hold an even number. A mismatch sets `frame_err_o`.
- R5: With `two_stop_i`=0 the receiver checks one stop bit; with `two_stop_i`=1 it checks two. A 0 sampled in any checked stop bit sets `frame_err_o`.
- R6: Each confirmed character sets exactly one outcome in the cycle after `eoc_o`. The choice follows this priority:
  - Frame error comes first, if parity or any stop bit is wrong.
  - Otherwise overrun is set, if `ready_o` is still set and not being acknowledged. `ready_o` stays set in that case.
  - Otherwise `ready_o` is set.
  In every case `data_o` takes the new byte.
- R7: A one-cycle `ack_i` clears `ready_o`, `overrun_o` and `frame_err_o` on the next clock. A character completing in the same cycle has priority.
- R8: If the line is 1 at the half-bit point of a start bit, the receiver returns to idle. `run_o` never rises and no flag changes.
- R9: `start_o` rises in the clock after the receiver sees `rx_i` fall from 1 to 0 while idle. `run_o` rises `(cpb_i>>1)+1` cycles after `start_o`. Both stay high until the character ends.
- R10: With `PRECISE_STOP`=0 (the default), `stop_o` rises `9*cpb_i + (cpb_i>>1)` cycles after `start_o`, which is mid parity bit. With `PRECISE_STOP`=1, it rises `10*cpb_i` cycles after `start_o`, which is the start of the first stop bit.
- R11: `eoc_o` is a one-cycle pulse on the final clock of the last stop bit. It comes `11*cpb_i-1` cycles after `start_o` with one stop bit and `12*cpb_i-1` cycles after with two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpb_i | input | CPB_W (13) | Clocks per bit, at least 3 |
| two_stop_i | input | 1 | 0: one stop bit, 1: two stop bits |
| odd_par_i | input | 1 | 1: odd parity, 0: even parity |
| msb_first_i | input | 1 | 1: data bit 7 first, 0: data bit 0 first |
| ack_i | input | 1 | Clears the three flags |
| rx_i | input | 1 | Serial line, idle high |
| data_o | output | DATA_W (8) | Last received byte |
| ready_o | output | 1 | Byte ready, sticky |
| overrun_o | output | 1 | Byte completed while the previous one was unacknowledged, sticky |
| frame_err_o | output | 1 | Parity or stop bit error, sticky |
| eoc_o | output | 1 | End-of-character pulse |
| start_o | output | 1 | Start seen, not yet confirmed or character in progress |
| run_o | output | 1 | Character confirmed and in progress |
| stop_o | output | 1 | Stop region reached |

## Verification
The bench builds the receiver with `CPB_W`=13, `DATA_W`=8 and `PRECISE_STOP`=0. It then changes `cpb_i` at run time between 16, 7 and 372. The odd value checks the rounding of the half-bit point. The value 372 shows that the full-width counter still lands every sample and every phase edge on the cycle predicted from R9 to R11. Because the bench uses the default stop-phase variant, it measures the mid-parity rise of `stop_o`.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_QUAL,
    ST_SBIT,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/sc_bit_timer.sv
module sc_bit_timer #(
  parameter int CPB_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CPB_W-1:0] cpb_i,
  output logic             mid_o,
  output logic             late_o,
  output logic             end_o
);
  logic [CPB_W-1:0] cnt_q;
  logic [CPB_W-1:0] mid_pt;

  assign mid_pt = cpb_i >> 1;
  assign mid_o  = (cnt_q == mid_pt);
  assign late_o = (cnt_q >= mid_pt);
  assign end_o  = (cnt_q >= cpb_i - CPB_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || end_o)    cnt_q <= '0;
    else                        cnt_q <= cnt_q + CPB_W'(1);
  end

  AST_MID_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpb_i >= CPB_W'(3) && mid_o && !clr_i) |=> !mid_o); // R2
endmodule

// File: rtl/sc_rx_seq.sv
module sc_rx_seq
  import sc_rx_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter bit PRECISE_STOP = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              msb_first_i,
  input  logic              odd_par_i,
  input  logic              two_stop_i,
  input  logic              mid_i,
  input  logic              late_i,
  input  logic              end_i,
  output logic              clr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              done_o,
  output logic              bad_o,
  output logic              start_o,
  output logic              run_o,
  output logic              stop_o
);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  rx_state_e         st_q, st_d;
  logic              rx_q;
  logic [DATA_W-1:0] sh_q;
  logic [IDX_W-1:0]  idx_q;
  logic              sidx_q;
  logic              par_err_q;
  logic              stop_bad_q;
  logic              last_stop;

  assign last_stop = (sidx_q == two_stop_i);
  assign clr_o     = (st_q == ST_IDLE);
  assign done_o    = (st_q == ST_STOP) && end_i && last_stop;
  assign bad_o     = par_err_q | stop_bad_q;
  assign start_o   = (st_q != ST_IDLE);
  assign run_o     = (st_q != ST_IDLE) && (st_q != ST_QUAL);

  generate
    if (PRECISE_STOP) begin : g_stop_exact
      assign stop_o = (st_q == ST_STOP);
    end else begin : g_stop_mid_par
      assign stop_o = (st_q == ST_STOP) || ((st_q == ST_PAR) && late_i);
    end
  endgenerate

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (rx_q && !rx_i) st_d = ST_QUAL;
      ST_QUAL: if (mid_i) st_d = rx_i ? ST_IDLE : ST_SBIT;
      ST_SBIT: if (end_i) st_d = ST_DATA;
      ST_DATA: if (end_i && idx_q == IDX_W'(DATA_W-1)) st_d = ST_PAR;
      ST_PAR:  if (end_i) st_d = ST_STOP;
      ST_STOP: if (end_i && last_stop) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      rx_q       <= 1'b1;
      sh_q       <= '0;
      idx_q      <= '0;
      sidx_q     <= 1'b0;
      par_err_q  <= 1'b0;
      stop_bad_q <= 1'b0;
      data_o     <= '0;
    end else begin
      st_q <= st_d;
      rx_q <= rx_i;
      unique case (st_q)
        ST_SBIT: idx_q <= '0;
        ST_DATA: begin
          if (mid_i) begin
            if (msb_first_i) sh_q <= {sh_q[DATA_W-2:0], rx_i};
            else             sh_q <= {rx_i, sh_q[DATA_W-1:1]};
          end
          if (end_i) idx_q <= idx_q + IDX_W'(1);
        end
        ST_PAR: begin
          if (mid_i) par_err_q <= ((^sh_q) ^ rx_i) != odd_par_i;
          if (end_i) begin
            sidx_q     <= 1'b0;
            stop_bad_q <= 1'b0;
          end
        end
        ST_STOP: begin
          if (mid_i && !rx_i) stop_bad_q <= 1'b1;
          if (end_i && !last_stop) sidx_q <= 1'b1;
          if (done_o) data_o <= sh_q;
        end
        default: ;
      endcase
    end
  end

  AST_RUN_IN_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |-> start_o); // R9
  AST_EOC_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
  AST_GLITCH_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_QUAL && mid_i && rx_i) |=> (!run_o && !start_o)); // R8
  AST_STOP_IN_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> run_o); // R10
endmodule

// File: rtl/sc_rx_flags.sv
module sc_rx_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_i,
  input  logic bad_i,
  input  logic ack_i,
  output logic ready_o,
  output logic overrun_o,
  output logic frame_err_o
);
  logic pend;
  logic good;

  assign pend = ready_o & ~ack_i;
  assign good = done_i & ~bad_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_o     <= 1'b0;
      overrun_o   <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      if (done_i && bad_i)  frame_err_o <= 1'b1;
      else if (ack_i)       frame_err_o <= 1'b0;
      if (good && pend)     overrun_o   <= 1'b1;
      else if (ack_i)       overrun_o   <= 1'b0;
      if (good && !pend)    ready_o     <= 1'b1;
      else if (ack_i)       ready_o     <= 1'b0;
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (ready_o || overrun_o || frame_err_o)); // R6
  AST_OVR_KEEPS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> ready_o); // R6
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !done_i) |=> (!ready_o && !overrun_o && !frame_err_o)); // R7
endmodule

// File: rtl/sc_char_rx.sv
module sc_char_rx #(
  parameter int CPB_W        = 13,
  parameter int DATA_W       = 8,
  parameter bit PRECISE_STOP = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CPB_W-1:0]  cpb_i,
  input  logic              two_stop_i,
  input  logic              odd_par_i,
  input  logic              msb_first_i,
  input  logic              ack_i,
  input  logic              rx_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ready_o,
  output logic              overrun_o,
  output logic              frame_err_o,
  output logic              eoc_o,
  output logic              start_o,
  output logic              run_o,
  output logic              stop_o
);
  logic clr, mid, late, bit_end, bad;

  sc_bit_timer #(.CPB_W(CPB_W)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .cpb_i  (cpb_i),
    .mid_o  (mid),
    .late_o (late),
    .end_o  (bit_end)
  );

  sc_rx_seq #(.DATA_W(DATA_W), .PRECISE_STOP(PRECISE_STOP)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_i        (rx_i),
    .msb_first_i (msb_first_i),
    .odd_par_i   (odd_par_i),
    .two_stop_i  (two_stop_i),
    .mid_i       (mid),
    .late_i      (late),
    .end_i       (bit_end),
    .clr_o       (clr),
    .data_o      (data_o),
    .done_o      (eoc_o),
    .bad_o       (bad),
    .start_o     (start_o),
    .run_o       (run_o),
    .stop_o      (stop_o)
  );

  sc_rx_flags i_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .done_i      (eoc_o),
    .bad_i       (bad),
    .ack_i       (ack_i),
    .ready_o     (ready_o),
    .overrun_o   (overrun_o),
    .frame_err_o (frame_err_o)
  );
endmodule

// File: tb/test_sc_char_rx.sv
`timescale 1ns/1ps
module test_sc_char_rx;
  localparam int CPB_W = 13;

  typedef struct {
    logic [7:0] d;
    bit r, o, f;
    int cpb;
    bit two;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CPB_W-1:0] cpb = 13'd16;
  logic two_stop = 1'b0, odd_par = 1'b0, msb_first = 1'b0, ack = 1'b0, rx = 1'b1;
  logic [7:0] data;
  logic ready, overrun, frame_err, eoc, start, run, stop;

  int n_chk = 0, n_fail = 0, cyc = 0, popped = 0, pushed = 0;
  bit m_r = 0, m_o = 0, m_f = 0;
  exp_t q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sc_char_rx i_sc_char_rx (
    .clk_i(clk), .rst_ni(rst_n), .cpb_i(cpb), .two_stop_i(two_stop),
    .odd_par_i(odd_par), .msb_first_i(msb_first), .ack_i(ack), .rx_i(rx),
    .data_o(data), .ready_o(ready), .overrun_o(overrun), .frame_err_o(frame_err),
    .eoc_o(eoc), .start_o(start), .run_o(run), .stop_o(stop)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle_bits(input int n);
    rx = 1'b1;
    repeat (n * int'(cpb)) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input bit par_flip,
                      input bit [1:0] stop_bad, input string tag);
    exp_t e;
    logic par;
    bit bad;
    par = odd_par ? ~(^b) : (^b);
    par = par ^ par_flip;
    bad = par_flip || stop_bad[0] || (two_stop && stop_bad[1]);
    e.d = b; e.cpb = int'(cpb); e.two = two_stop; e.tag = tag;
    e.r = m_r; e.o = m_o; e.f = m_f;
    if (bad) e.f = 1;
    else if (m_r) e.o = 1;
    else e.r = 1;
    m_r = e.r; m_o = e.o; m_f = e.f;
    q.push_back(e); pushed++;
    rx = 1'b0; repeat (int'(cpb)) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = msb_first ? b[7-i] : b[i];
      repeat (int'(cpb)) @(negedge clk);
    end
    rx = par; repeat (int'(cpb)) @(negedge clk);
    rx = ~stop_bad[0]; repeat (int'(cpb)) @(negedge clk);
    if (two_stop) begin
      rx = ~stop_bad[1]; repeat (int'(cpb)) @(negedge clk);
    end
    idle_bits(3);
  endtask

  task automatic do_ack();
    ack = 1'b1; @(negedge clk);
    ack = 1'b0;
    chk(!ready && !overrun && !frame_err, "R7", "flags after ack",
        {ready, overrun, frame_err}, 0);
    m_r = 0; m_o = 0; m_f = 0;
    @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    int t_start, t_run, t_stop, half;
    bit p_start = 0, p_run = 0, p_stop = 0;
    exp_t e;
    t_start = 0; t_run = 0; t_stop = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (start && !p_start) t_start = cyc;
        if (run && !p_run) t_run = cyc;
        if (stop && !p_stop) t_stop = cyc;
        p_start = start; p_run = run; p_stop = stop;
        if (eoc) begin
          if (q.size() == 0) begin
            chk(0, "R6", "unexpected character", 1, 0);
          end else begin
            e = q.pop_front(); popped++;
            half = e.cpb / 2;
            chk(t_run - t_start == half + 1, "R9", "run delay",
                t_run - t_start, half + 1);
            chk(t_stop - t_start == 9 * e.cpb + half, "R10", "stop delay",
                t_stop - t_start, 9 * e.cpb + half);
            chk(cyc - t_start == (e.two ? 12 : 11) * e.cpb - 1, "R11", "eoc delay",
                cyc - t_start, (e.two ? 12 : 11) * e.cpb - 1);
            @(negedge clk);
            p_start = start; p_run = run; p_stop = stop;
            chk(!eoc, "R11", "eoc width", eoc, 0);
            chk(data == e.d, e.tag, "data", data, e.d);
            chk({ready, overrun, frame_err} == {e.r, e.o, e.f}, e.tag, "flags r/o/f",
                {ready, overrun, frame_err}, {e.r, e.o, e.f});
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "R1", "watchdog expired", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit saw_run;
    repeat (3) @(negedge clk);
    chk({data, ready, overrun, frame_err, eoc, start, run, stop} == '0, "R1",
        "reset outputs", {data, ready, overrun, frame_err, eoc, start, run, stop}, 0);
    rst_n = 1'b1;
    idle_bits(1);

    // LSB first, even parity, one stop
    send(8'hB4, 0, 2'b00, "R2");
    do_ack();
    // MSB first, odd parity
    msb_first = 1; odd_par = 1;
    send(8'h1E, 0, 2'b00, "R3");
    do_ack();
    msb_first = 0;
    send(8'h61, 0, 2'b00, "R3");
    do_ack();
    // wrong parity
    odd_par = 0;
    send(8'h5A, 1, 2'b00, "R4");
    do_ack();
    // odd cpb, two stops, then overrun without ack
    cpb = 13'd7; two_stop = 1;
    send(8'hC3, 0, 2'b00, "R5");
    send(8'h27, 0, 2'b00, "R6");
    do_ack();
    // bad second stop bit
    send(8'h99, 0, 2'b10, "R5");
    do_ack();
    // bad single stop
    two_stop = 0; cpb = 13'd16;
    send(8'h0F, 0, 2'b01, "R5");
    do_ack();
    // glitch shorter than half a bit
    saw_run = 0;
    rx = 1'b0; repeat (3) @(negedge clk);
    chk(start, "R9", "start on edge", start, 1);
    rx = 1'b1;
    repeat (2 * int'(cpb)) begin
      @(negedge clk);
      if (run) saw_run = 1;
    end
    chk(!saw_run, "R8", "run after glitch", saw_run, 0);
    chk(!start, "R8", "start dropped", start, 0);
    chk({ready, overrun, frame_err} == 3'b000, "R8", "flags after glitch",
        {ready, overrun, frame_err}, 0);
    // default elementary time unit
    cpb = 13'd372; odd_par = 1;
    send(8'hE2, 0, 2'b00, "R2");
    idle_bits(1);
    chk(q.size() == 0 && popped == pushed, "R6", "all characters seen",
        popped, pushed);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule